// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block steps a processor through taking an exception and coming back from it. An arbiter outside the block raises a flag when a pending exception is more urgent than whatever is currently running, and presents that exception's vector. The sequencer then moves the stack pointer down by one frame and saves eight words, one per accepted memory beat. It fetches the vector and pulses a handler-start strobe. When the core reports that the handler has finished, the sequencer restores the eight words in reverse order and moves the stack pointer back up.

Two shortcuts save bus cycles. If a handler finishes while the arbiter still flags a pending exception, the saved frame is kept and the next vector is fetched at once. This is tail-chaining. If a more urgent request arrives while the frame is still being saved, it takes over the vector and no second save is needed. A request that arrives once a handler is running is a true preemption. It costs a new frame, up to a parameterised nesting limit. When a nested frame has been restored, the interrupted handler resumes without a new start strobe.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset every strobe (sp_dec, sp_inc, save_en, restore_en, vec_fetch, handler_start) is low, the block is idle, and sp_amount reads the frame size in bytes (32 by default).
- R2: A pending request while idle gives one sp_dec pulse in the first stacking cycle, then eight save beats with word_idx 0,1,...,7, then a vector fetch, then a one-cycle handler_start carrying the vector. With mem_ready held high, handler_start is high in the tenth cycle after the cycle in which pend_valid was first sampled.
- R3: A save, restore or vector-fetch beat completes only in a cycle where mem_ready is high. While mem_ready is low, word_idx and vec_addr hold their values.
- R4: exc_return with no pending request gives eight restore beats with word_idx 7,6,...,0 and one sp_inc pulse, in the cycle of the final beat (word_idx 0).
- R5: When a restore finishes and no frame is left, the block goes idle. If a preempted frame remains, the block goes back to that handler without a handler_start pulse.
- R6: exc_return sampled together with pend_valid skips the restore. There is no restore beat, no sp_inc and no sp_dec, and the block goes straight to a vector fetch and a handler_start carrying the new vector.
- R7: A pend_valid seen during stacking, up to and including the last save beat, replaces the vector. The handler started is the last vector presented, and only one frame (eight saves, one sp_dec) is spent.
- R8: pend_valid while a handler runs, without exc_return, starts a fresh full stacking with its own sp_dec.
- R9: With MAX_NEST frames already saved, pend_valid while a handler runs starts no stacking.
- R10: At most one of save_en, restore_en and vec_fetch is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pend_valid | input | 1 | Arbiter: an exception more urgent than the current one is pending |
| pend_vec | input | VEC_W | Vector of that pending exception |
| exc_return | input | 1 | Core: the running handler has finished (one-cycle pulse) |
| mem_ready | input | 1 | Memory accepts the current beat this cycle |
| sp_dec | output | 1 | Lower the stack pointer by sp_amount |
| sp_inc | output | 1 | Raise the stack pointer by sp_amount |
| sp_amount | output | AMT_W | Frame size in bytes |
| save_en | output | 1 | Save beat request for word word_idx |
| restore_en | output | 1 | Restore beat request for word word_idx |
| word_idx | output | IDX_W | Frame word addressed by the current beat |
| vec_fetch | output | 1 | Vector fetch request |
| vec_addr | output | VEC_W | Vector being fetched |
| handler_start | output | 1 | One-cycle strobe: the handler begins |
| handler_vec | output | VEC_W | Vector of the handler being started |

## Verification
A nesting counter that drifts by one shows up one exception return later, at the ports. Either the block goes idle while a preempted handler should resume, or it goes back to a handler when it should be idle. This is seen as missing or extra restore beats within about ten cycles of the return. A stale vector register shows up as a wrong handler_vec on the very next handler_start, and the late-arrival and tail-chain cases are where this is most likely. A beat counter that miscounts or ignores mem_ready shows up during the same frame. The save and restore counts come out other than eight, word_idx breaks its ascending or descending order, or the ten-cycle entry latency moves.

// File: rtl/exc_seq_pkg.sv
// Shared types for the exception sequencer.
package exc_seq_pkg;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_STACK     = 3'd1,
        ST_VECTOR    = 3'd2,
        ST_HANDLER   = 3'd3,
        ST_UNSTACK   = 3'd4,
        ST_TAILCHAIN = 3'd5
    } seq_state_t;

endpackage

// File: rtl/exc_beat_ctr.sv
// Beat counter for frame save/restore.
// Counts accepted beats 0..BEATS-1 and wraps to zero after the last one.
// Assumes every frame transfer runs to completion, so no clear is needed.
module exc_beat_ctr #(
    parameter int unsigned BEATS = 8,
    parameter int unsigned IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output logic             last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

    logic [IDX_W-1:0] cnt_q;

    // Advance on each accepted beat and wrap after the final one
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (step)      cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    end

    assign idx  = cnt_q;
    assign last = (cnt_q == LAST_IDX);

    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q));                                    // R3
    AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (cnt_q == '0));                            // R2

endmodule

// File: rtl/exc_nest_track.sv
// Counts frames currently saved on the stack.
// push when a stacking phase completes, pop when an unstacking completes.
// Assumes the controller never pushes when full nor pops when empty.
module exc_nest_track #(
    parameter int unsigned MAX_NEST = 2,
    parameter int unsigned DEPTH_W  = $clog2(MAX_NEST + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic full,
    output logic multi
);
    logic [DEPTH_W-1:0] depth_q;

    // Track the number of saved frames
    always_ff @(posedge clk) begin
        if (!rst_n)             depth_q <= '0;
        else if (push && !pop)  depth_q <= depth_q + 1'b1;
        else if (pop && !push)  depth_q <= depth_q - 1'b1;
    end

    assign full  = (depth_q == DEPTH_W'(MAX_NEST));
    assign multi = (depth_q > DEPTH_W'(1));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);                                              // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (depth_q != '0));                                     // R5

endmodule

// File: rtl/exc_vec_hold.sv
// Holds the vector that will be fetched and started.
// Loads on request, otherwise keeps its value.
module exc_vec_hold #(
    parameter int unsigned VEC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] d,
    output logic [VEC_W-1:0] q
);
    // Capture the vector when told to
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (load)  q <= d;
    end

    AST_VEC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));                                        // R7

endmodule

// File: rtl/exc_entry_seq.sv
// Exception entry/return sequencer with tail-chaining and late arrival.
// Steps IDLE -> STACK -> VECTOR -> HANDLER -> UNSTACK/TAILCHAIN.
// Assumes the arbiter raises pend_valid only for a request more urgent
// than the current one, and drops it once handler_start is seen.
// Memory beats move one word per cycle when mem_ready is high.
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int unsigned VEC_W       = 6,
    parameter int unsigned FRAME_WORDS = 8,
    parameter int unsigned WORD_BYTES  = 4,
    parameter int unsigned MAX_NEST    = 2,
    parameter int unsigned IDX_W       = (FRAME_WORDS > 1) ? $clog2(FRAME_WORDS) : 1,
    parameter int unsigned AMT_W       = $clog2(FRAME_WORDS * WORD_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_valid,
    input  logic [VEC_W-1:0] pend_vec,
    input  logic             exc_return,
    input  logic             mem_ready,
    output logic             sp_dec,
    output logic             sp_inc,
    output logic [AMT_W-1:0] sp_amount,
    output logic             save_en,
    output logic             restore_en,
    output logic [IDX_W-1:0] word_idx,
    output logic             vec_fetch,
    output logic [VEC_W-1:0] vec_addr,
    output logic             handler_start,
    output logic [VEC_W-1:0] handler_vec
);
    localparam int unsigned      FRAME_BYTES = FRAME_WORDS * WORD_BYTES;
    localparam logic [IDX_W-1:0] TOP_IDX     = IDX_W'(FRAME_WORDS - 1);

    seq_state_t       state_q, state_d;
    logic             dec_q, dec_d;
    logic             hs_q, hs_d;
    logic             beat_step, beat_last;
    logic [IDX_W-1:0] beat_idx;
    logic             push, pop, nest_full, nest_multi;
    logic             vec_load;
    logic [VEC_W-1:0] vec_q;

    // Beat counter shared by save and restore phases
    exc_beat_ctr #(.BEATS(FRAME_WORDS), .IDX_W(IDX_W)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (beat_step),
        .idx   (beat_idx),
        .last  (beat_last)
    );

    // Count of frames on the stack
    exc_nest_track #(.MAX_NEST(MAX_NEST)) u_nest (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .full  (nest_full),
        .multi (nest_multi)
    );

    // Vector to be fetched next
    exc_vec_hold #(.VEC_W(VEC_W)) u_vec (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (vec_load),
        .d     (pend_vec),
        .q     (vec_q)
    );

    assign beat_step = ((state_q == ST_STACK) || (state_q == ST_UNSTACK)) && mem_ready;

    // Next-state, vector capture and frame bookkeeping
    always_comb begin
        state_d  = state_q;
        dec_d    = 1'b0;
        hs_d     = 1'b0;
        vec_load = 1'b0;
        push     = 1'b0;
        pop      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_valid) begin
                    state_d  = ST_STACK;
                    vec_load = 1'b1;
                    dec_d    = 1'b1;
                end
            end
            ST_STACK: begin
                if (pend_valid) vec_load = 1'b1;
                if (beat_step && beat_last) begin
                    state_d = ST_VECTOR;
                    push    = 1'b1;
                end
            end
            ST_VECTOR: begin
                if (mem_ready) begin
                    state_d = ST_HANDLER;
                    hs_d    = 1'b1;
                end
            end
            ST_HANDLER: begin
                if (exc_return) begin
                    state_d = pend_valid ? ST_TAILCHAIN : ST_UNSTACK;
                end else if (pend_valid && !nest_full) begin
                    state_d  = ST_STACK;
                    vec_load = 1'b1;
                    dec_d    = 1'b1;
                end
            end
            ST_UNSTACK: begin
                if (beat_step && beat_last) begin
                    pop     = 1'b1;
                    state_d = nest_multi ? ST_HANDLER : ST_IDLE;
                end
            end
            ST_TAILCHAIN: begin
                vec_load = 1'b1;
                state_d  = ST_VECTOR;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and one-cycle strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dec_q   <= 1'b0;
            hs_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            dec_q   <= dec_d;
            hs_q    <= hs_d;
        end
    end

    assign sp_amount     = AMT_W'(FRAME_BYTES);
    assign sp_dec        = dec_q;
    assign sp_inc        = (state_q == ST_UNSTACK) && beat_step && beat_last;
    assign save_en       = (state_q == ST_STACK);
    assign restore_en    = (state_q == ST_UNSTACK);
    assign word_idx      = restore_en ? (TOP_IDX - beat_idx) : beat_idx;
    assign vec_fetch     = (state_q == ST_VECTOR);
    assign vec_addr      = vec_q;
    assign handler_start = hs_q;
    assign handler_vec   = vec_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_en, restore_en, vec_fetch}));                  // R10
    AST_START_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |-> $past(vec_fetch && mem_ready));             // R2
    AST_DEC_AT_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        sp_dec |-> (save_en && word_idx == '0));                      // R2
    AST_TAILCHAIN_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HANDLER && exc_return && pend_valid)
            |=> (!restore_en && !sp_dec && !save_en));                // R6
    AST_FETCH_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_fetch && !mem_ready) |=> (vec_fetch && $stable(vec_addr))); // R3

endmodule

// File: tb/exc_entry_seq_tb.sv
// Directed bench for exc_entry_seq: one task per scenario.
module exc_entry_seq_tb;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pend_valid = 1'b0;
    logic [VW-1:0] pend_vec = '0;
    logic          exc_return = 1'b0;
    logic          mem_ready = 1'b1;
    logic          sp_dec, sp_inc, save_en, restore_en, vec_fetch, handler_start;
    logic [5:0]    sp_amount;
    logic [2:0]    word_idx;
    logic [VW-1:0] vec_addr, handler_vec;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pend_valid(pend_valid), .pend_vec(pend_vec),
        .exc_return(exc_return), .mem_ready(mem_ready), .sp_dec(sp_dec),
        .sp_inc(sp_inc), .sp_amount(sp_amount), .save_en(save_en),
        .restore_en(restore_en), .word_idx(word_idx), .vec_fetch(vec_fetch),
        .vec_addr(vec_addr), .handler_start(handler_start), .handler_vec(handler_vec)
    );

    // Port monitor: cumulative counts sampled at the falling edge
    int n_save = 0, n_rest = 0, n_dec = 0, n_inc = 0, n_hs = 0;
    int ord_err = 0, excl_err = 0;
    logic [VW-1:0] last_hs_vec = '0, last_fetch = '0;
    logic [2:0]    inc_idx = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (save_en && mem_ready) begin
                if (word_idx != 3'(n_save % 8)) ord_err++;
                n_save++;
            end
            if (restore_en && mem_ready) begin
                if (word_idx != 3'(7 - (n_rest % 8))) ord_err++;
                n_rest++;
            end
            if (sp_dec) n_dec++;
            if (sp_inc) begin n_inc++; inc_idx = word_idx; end
            if (handler_start) begin n_hs++; last_hs_vec = handler_vec; end
            if (vec_fetch && mem_ready) last_fetch = vec_addr;
            if (32'(save_en) + 32'(restore_en) + 32'(vec_fetch) > 1) excl_err++;
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait for handler_start, return the number of cycles it took
    task automatic wait_hs(output int cyc);
        cyc = 0;
        for (int k = 1; k <= 200; k++) begin
            tick();
            if (handler_start) begin cyc = k; break; end
        end
        pend_valid = 1'b0;
    endtask

    task automatic enter(input logic [VW-1:0] v);
        int c;
        pend_vec = v; pend_valid = 1'b1;
        wait_hs(c);
    endtask

    // Pulse exc_return and wait for the frame restore to finish
    task automatic do_return();
        int i0 = n_inc;
        exc_return = 1'b1; tick(); exc_return = 1'b0;
        for (int k = 0; k < 100 && n_inc == i0; k++) tick();
        tick();
    endtask

    task automatic t_reset();
        check(!sp_dec && !sp_inc && !save_en && !restore_en && !vec_fetch && !handler_start,
              "R1 strobes", 32'({sp_dec, sp_inc, save_en, restore_en, vec_fetch, handler_start}), 0);
        check(sp_amount == 6'd32, "R1 amount", 32'(sp_amount), 32);
    endtask

    task automatic t_entry_return();
        int s0 = n_save, d0 = n_dec, r0 = n_rest, i0 = n_inc, h0, c;
        pend_vec = 6'd5; pend_valid = 1'b1;
        wait_hs(c);
        check(c == 10, "R2 latency", c, 10);
        check(n_save - s0 == 8, "R2 saves", n_save - s0, 8);
        check(n_dec - d0 == 1, "R2 sp_dec", n_dec - d0, 1);
        check(last_hs_vec == 6'd5, "R2 vector", 32'(last_hs_vec), 5);
        check(last_fetch == 6'd5, "R2 fetch addr", 32'(last_fetch), 5);
        do_return();
        check(n_rest - r0 == 8, "R4 restores", n_rest - r0, 8);
        check(n_inc - i0 == 1, "R4 sp_inc", n_inc - i0, 1);
        check(inc_idx == 3'd0, "R4 inc on last beat", 32'(inc_idx), 0);
        h0 = n_hs; s0 = n_save; r0 = n_rest;
        for (int k = 0; k < 6; k++) tick();
        check(n_hs == h0 && n_save == s0 && n_rest == r0, "R5 idle after last frame",
              n_hs - h0 + n_save - s0 + n_rest - r0, 0);
        check(ord_err == 0, "R2 R4 word order", ord_err, 0);
    endtask

    task automatic t_late();
        int s0 = n_save, d0 = n_dec, c;
        pend_vec = 6'd3; pend_valid = 1'b1;
        for (int k = 0; k < 50 && n_save - s0 < 3; k++) tick();
        pend_vec = 6'd9;
        wait_hs(c);
        check(last_hs_vec == 6'd9, "R7 late vector", 32'(last_hs_vec), 9);
        check(n_save - s0 == 8, "R7 single frame", n_save - s0, 8);
        check(n_dec - d0 == 1, "R7 single sp_dec", n_dec - d0, 1);
        do_return();
    endtask

    task automatic t_tailchain();
        int s0, d0, r0, i0, c;
        enter(6'd1);
        s0 = n_save; d0 = n_dec; r0 = n_rest; i0 = n_inc;
        pend_vec = 6'd4; pend_valid = 1'b1; exc_return = 1'b1;
        tick(); exc_return = 1'b0;
        wait_hs(c);
        check(c > 0 && last_hs_vec == 6'd4, "R6 tail vector", 32'(last_hs_vec), 4);
        check(n_rest == r0 && n_inc == i0, "R6 no restore", n_rest - r0 + n_inc - i0, 0);
        check(n_save == s0 && n_dec == d0, "R6 no restack", n_save - s0 + n_dec - d0, 0);
        r0 = n_rest;
        do_return();
        check(n_rest - r0 == 8, "R6 frame kept then restored", n_rest - r0, 8);
    endtask

    task automatic t_preempt();
        int s0, d0, r0, h0;
        enter(6'd1);
        s0 = n_save; d0 = n_dec;
        enter(6'd2);
        check(n_save - s0 == 8, "R8 second frame", n_save - s0, 8);
        check(n_dec - d0 == 1, "R8 sp_dec", n_dec - d0, 1);
        check(last_hs_vec == 6'd2, "R8 vector", 32'(last_hs_vec), 2);
        h0 = n_hs; r0 = n_rest;
        do_return();
        for (int k = 0; k < 6; k++) tick();
        check(n_hs == h0, "R5 resume without start", n_hs - h0, 0);
        check(n_rest - r0 == 8, "R5 resumed, no extra restore", n_rest - r0, 8);
        do_return();
        check(n_rest - r0 == 16, "R5 outer frame restored", n_rest - r0, 16);
    endtask

    task automatic t_limit();
        int s0, d0;
        enter(6'd1);
        enter(6'd2);
        s0 = n_save; d0 = n_dec;
        pend_vec = 6'd7; pend_valid = 1'b1;
        for (int k = 0; k < 20; k++) tick();
        pend_valid = 1'b0;
        check(n_save == s0 && n_dec == d0, "R9 no stacking at limit", n_save - s0, 0);
        do_return();
        do_return();
    endtask

    task automatic t_stall();
        int s0 = n_save, c;
        logic [2:0] held;
        pend_vec = 6'd6; pend_valid = 1'b1;
        for (int k = 0; k < 50 && n_save - s0 < 2; k++) tick();
        mem_ready = 1'b0; tick();
        held = word_idx;
        for (int k = 0; k < 5; k++) tick();
        check(n_save - s0 == 2, "R3 no beat while stalled", n_save - s0, 2);
        check(word_idx == held, "R3 index held", 32'(word_idx), 32'(held));
        mem_ready = 1'b1;
        wait_hs(c);
        check(n_save - s0 == 8 && last_hs_vec == 6'd6, "R3 frame completes", n_save - s0, 8);
        do_return();
    endtask

    // Watchdog
    initial begin
        #2ms;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) tick();
        t_reset();
        rst_n = 1'b1; tick();
        t_entry_return();
        t_late();
        t_tailchain();
        t_preempt();
        t_limit();
        t_stall();
        check(excl_err == 0, "R10 strobe exclusivity", excl_err, 0);
        check(ord_err == 0, "R2 R4 word order overall", ord_err, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule